// File: doc/BRIEF.md
# Drum word transfer engine

This block moves one block of words between main memory and a rotating drum store. It is started once the drum has turned to the first target word. For each word it copies the data in the chosen direction and steps both addresses. It counts the block length down and folds every moved word into a running 12-bit check value. Between words it waits one word time. When the next drum address is the first word of a sector, it waits for the whole inter-sector gap instead.

The surrounding channel controller decodes the drum program and works out the rotational latency. It then offers a start with a direction, a core address, a drum address and a count, and resumes fetching commands when the engine pulses done. Memory and drum storage are each reached through a request/acknowledge port. A missing drum store raises a sticky error flag and abandons the block.

The drum address has three fields: word in the low `WORD_BITS` bits, then sector, then track. The defaults are 11, 3 and 7 bits with 84 tracks, and the gap is 236 word times.

Top module: `drum_xfer_engine`

## Requirements
- R1: Drum addresses run from 0 to NUM_TRACKS·2^(SECT_BITS+WORD_BITS)−1. The word field is bits WORD_BITS−1..0, the sector field sits above it and the track field above that. After the last drum word the next word goes to drum address 0.
- R2: In a write block (startWrite=1), each word is read from memory at the core address (memWe=0). The same value is then written to the drum at the drum address (drmWe=1).
- R3: In a read block (startWrite=0), each word is read from the drum (drmWe=0). The same value is then written to memory at the core address (memWe=1).
- R4: After each word, the core address increments modulo 2^CORE_AW and the drum address steps as in R1. The count decrements, and exactly startCount words move (1 ≤ startCount < 2^WC_W). No memory or drum location outside the block changes, except the R11 word.
- R5: parityOut clears to 0 at start. For each moved word w it becomes rotl1(parityOut ^ w[23:12]) ^ w[11:0], where rotl1 is a one-bit left rotate within 12 bits.
- R6: When the next drum address does not start a sector, the next word's source request rises WORD_TIME cycles after the edge that accepts the previous word's destination acknowledge.
- R7: When the next drum address has its word field at zero, that wait is GAP_WORDS·WORD_TIME cycles instead.
- R8: After the last word, donePulse is high for exactly one cycle, and startReady is high in the following cycle.
- R9: If drmPresent is low when a word falls due (at the start edge or at the end of a wait), errFlag sets. No request is issued for that word, the engine returns to idle and donePulse stays low.
- R10: errFlag stays set across later blocks until reset or a clrErr cycle. If a new error occurs in the same cycle as clrErr, the error wins.
- R11: With PAR_CLOBBER=1, a write block whose next drum address is mid-sector gets one extra drum write to that address: the final check value in bits 23:12 and zeros in bits 11:0. A block ending on a sector start gets no extra write.
- R12: A request and its direction stay asserted until its acknowledge. Memory and drum requests are never asserted together. startValid is ignored while startReady is low.
- R13: After reset: startReady=1, memReq=0, drmReq=0, errFlag=0, donePulse=0, parityOut=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start a block (taken only when idle) |
| startWrite | input | 1 | 1: memory to drum, 0: drum to memory |
| startCore | input | CORE_AW | First core address |
| startDrum | input | DA_W | First drum address (track, sector, word) |
| startCount | input | WC_W | Number of words |
| startReady | output | 1 | Engine idle |
| clrErr | input | 1 | Clear the error flag |
| drmPresent | input | 1 | Drum storage is available |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | CORE_AW | Memory address |
| memWrData | output | DATA_W | Memory write data |
| memAck | input | 1 | Memory acknowledge |
| memRdData | input | DATA_W | Memory read data, valid with memAck |
| drmReq | output | 1 | Drum request |
| drmWe | output | 1 | Drum request is a write |
| drmAddr | output | DA_W | Drum address |
| drmWrData | output | DATA_W | Drum write data |
| drmAck | input | 1 | Drum acknowledge |
| drmRdData | input | DATA_W | Drum read data, valid with drmAck |
| errFlag | output | 1 | Sticky error flag |
| donePulse | output | 1 | One-cycle end-of-block pulse |
| parityOut | output | DATA_W/2 | Running check value |

## Verification
Some properties are checked every cycle. A request holds with a steady direction until acknowledged, and the two ports are never requested together. The drum address stays in range, and the addresses hold between word steps. The done pulse lasts one cycle and leads straight to idle. The error flag cannot drop without a clear, and an absent store at start issues no request.

Other behaviour only the bench scenarios can show. These are the data actually landing at the right addresses in both directions, and the drum and core wraps. They also include the check-value arithmetic and the extra check-value word at a mid-sector end. Finally, there is the exact block duration, which exposes the one-word versus full-gap spacing at sector starts.

// File: rtl/drum_xfer_pkg.sv
package drum_xfer_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // latch start parameters, clear check value
    logic capture;  // latch source data
    logic advance;  // word finished: step addresses, count, check value
    logic clobber;  // drum write data is the check value word
  } xfer_strobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SRC,
    S_DST,
    S_WAIT,
    S_CLOB,
    S_DONE
  } xfer_state_t;

endpackage

// File: rtl/drum_xfer_dp.sv
module drum_xfer_dp
  import drum_xfer_pkg::*;
#(
  parameter int CORE_AW    = 14,
  parameter int DA_W       = 21,
  parameter int WC_W       = 14,
  parameter int DATA_W     = 24,
  parameter int WORD_BITS  = 11,
  parameter int DRUM_WORDS = 84 * 16384
) (
  input  logic                clk,
  input  logic                rstN,
  input  xfer_strobe_t        stb,
  input  logic                startWrite,
  input  logic [CORE_AW-1:0]  startCore,
  input  logic [DA_W-1:0]     startDrum,
  input  logic [WC_W-1:0]     startCount,
  input  logic [DATA_W-1:0]   memRdData,
  input  logic [DATA_W-1:0]   drmRdData,
  output logic [CORE_AW-1:0]  coreAddr,
  output logic [DA_W-1:0]     drumAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W-1:0]   drmWrData,
  output logic [DATA_W/2-1:0] parity,
  output logic                dirWrite,
  output logic                nextWcZero,
  output logic                nextSectorStart
);

  localparam int PAR_W = DATA_W / 2;
  localparam logic [DA_W-1:0] DA_LAST = DA_W'(DRUM_WORDS - 1);

  logic [WC_W-1:0]   wordCnt;
  logic [DATA_W-1:0] dataReg;
  logic [DA_W-1:0]   drumNext;
  logic [WC_W-1:0]   cntNext;
  logic [PAR_W-1:0]  parMix;
  logic [PAR_W-1:0]  parNext;

  // Drum address steps and wraps at the end of the store
  assign drumNext        = (drumAddr == DA_LAST) ? '0 : drumAddr + 1'b1;
  assign cntNext         = wordCnt - 1'b1;
  assign nextWcZero      = (cntNext == '0);
  assign nextSectorStart = (drumNext[WORD_BITS-1:0] == '0);

  // Check value: fold upper half, rotate left by one, fold lower half
  assign parMix  = parity ^ dataReg[DATA_W-1:PAR_W];
  assign parNext = {parMix[PAR_W-2:0], parMix[PAR_W-1]} ^ dataReg[PAR_W-1:0];

  assign memWrData = dataReg;
  assign drmWrData = stb.clobber ? {parity, {PAR_W{1'b0}}} : dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreAddr <= '0;
      drumAddr <= '0;
      wordCnt  <= '0;
      dataReg  <= '0;
      parity   <= '0;
      dirWrite <= 1'b0;
    end else begin
      if (stb.load) begin
        coreAddr <= startCore;
        drumAddr <= startDrum;
        wordCnt  <= startCount;
        parity   <= '0;
        dirWrite <= startWrite;
      end
      if (stb.capture) begin
        dataReg <= dirWrite ? memRdData : drmRdData;
      end
      if (stb.advance) begin
        coreAddr <= coreAddr + 1'b1;
        drumAddr <= drumNext;
        wordCnt  <= cntNext;
        parity   <= parNext;
      end
    end
  end

  // R1: drum address never leaves the store
  p_da_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    drumAddr <= DA_LAST);

  // R4: addresses and count move only on a word step or a new start
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.advance && !stb.load) |=> ($stable(drumAddr) && $stable(coreAddr) && $stable(wordCnt)));

endmodule

// File: rtl/drum_xfer_ctrl.sv
module drum_xfer_ctrl
  import drum_xfer_pkg::*;
#(
  parameter int WORD_TIME   = 1,
  parameter int GAP_WORDS   = 236,
  parameter bit PAR_CLOBBER = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  input  logic         drmPresent,
  input  logic         clrErr,
  input  logic         memAck,
  input  logic         drmAck,
  input  logic         dirWrite,
  input  logic         nextWcZero,
  input  logic         nextSectorStart,
  output xfer_strobe_t stb,
  output logic         memReq,
  output logic         memWe,
  output logic         drmReq,
  output logic         drmWe,
  output logic         startReady,
  output logic         donePulse,
  output logic         errFlag
);

  localparam int SHORT_CYC = WORD_TIME;
  localparam int LONG_CYC  = GAP_WORDS * WORD_TIME;
  localparam int CNT_W     = $clog2(LONG_CYC + 1);

  xfer_state_t      state;
  logic [CNT_W-1:0] waitCnt;
  logic             srcAck;
  logic             dstAck;
  logic             errSet;
  logic             clobEn;
  logic             waitOver;

  if (PAR_CLOBBER) begin : g_clob
    assign clobEn = 1'b1;
  end else begin : g_noclob
    assign clobEn = 1'b0;
  end

  assign srcAck   = dirWrite ? memAck : drmAck;
  assign dstAck   = dirWrite ? drmAck : memAck;
  assign waitOver = (state == S_WAIT) && (waitCnt == '0);
  assign errSet   = ((state == S_IDLE) && startValid && !drmPresent) ||
                    (waitOver && !drmPresent);

  assign startReady = (state == S_IDLE);
  assign donePulse  = (state == S_DONE);

  always_comb begin
    stb    = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    drmReq = 1'b0;
    drmWe  = 1'b0;
    unique case (state)
      S_IDLE: stb.load = startValid && drmPresent;
      S_SRC: begin
        memReq      = dirWrite;
        drmReq      = !dirWrite;
        stb.capture = srcAck;
      end
      S_DST: begin
        drmReq      = dirWrite;
        drmWe       = dirWrite;
        memReq      = !dirWrite;
        memWe       = !dirWrite;
        stb.advance = dstAck;
      end
      S_CLOB: begin
        drmReq      = 1'b1;
        drmWe       = 1'b1;
        stb.clobber = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      errFlag <= 1'b0;
    end else begin
      if (errSet)      errFlag <= 1'b1;
      else if (clrErr) errFlag <= 1'b0;
      unique case (state)
        S_IDLE: if (startValid && drmPresent) state <= S_SRC;
        S_SRC:  if (srcAck) state <= S_DST;
        S_DST: begin
          if (dstAck) begin
            if (nextWcZero) begin
              state <= (clobEn && dirWrite && !nextSectorStart) ? S_CLOB : S_DONE;
            end else begin
              state   <= S_WAIT;
              waitCnt <= nextSectorStart ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
            end
          end
        end
        S_WAIT: begin
          if (waitCnt == '0) state <= drmPresent ? S_SRC : S_IDLE;
          else               waitCnt <= waitCnt - 1'b1;
        end
        S_CLOB: if (drmAck) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12: one port at a time
  p_one_port_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && drmReq));

  // R12: an unacknowledged request holds with its direction
  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

  p_drm_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (drmReq && !drmAck) |=> (drmReq && $stable(drmWe)));

  // R8: done lasts one cycle and returns to idle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> (!donePulse && startReady));

  // R10: the error flag only drops on a clear
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clrErr) |=> errFlag);

  // R9: absent store at start gives no request and stays idle
  p_absent_r9: assert property (@(posedge clk) disable iff (!rstN)
    (startReady && startValid && !drmPresent) |=> (startReady && !memReq && !drmReq && errFlag));

endmodule

// File: rtl/drum_xfer_engine.sv
module drum_xfer_engine
  import drum_xfer_pkg::*;
#(
  parameter int WORD_BITS   = 11,
  parameter int SECT_BITS   = 3,
  parameter int TRACK_BITS  = 7,
  parameter int NUM_TRACKS  = 84,
  parameter int GAP_WORDS   = 236,
  parameter int WORD_TIME   = 1,
  parameter int CORE_AW     = 14,
  parameter int WC_W        = 14,
  parameter int DATA_W      = 24,
  parameter bit PAR_CLOBBER = 1'b1,
  localparam int DA_W       = WORD_BITS + SECT_BITS + TRACK_BITS,
  localparam int PAR_W      = DATA_W / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic               startWrite,
  input  logic [CORE_AW-1:0] startCore,
  input  logic [DA_W-1:0]    startDrum,
  input  logic [WC_W-1:0]    startCount,
  output logic               startReady,
  input  logic               clrErr,
  input  logic               drmPresent,
  output logic               memReq,
  output logic               memWe,
  output logic [CORE_AW-1:0] memAddr,
  output logic [DATA_W-1:0]  memWrData,
  input  logic               memAck,
  input  logic [DATA_W-1:0]  memRdData,
  output logic               drmReq,
  output logic               drmWe,
  output logic [DA_W-1:0]    drmAddr,
  output logic [DATA_W-1:0]  drmWrData,
  input  logic               drmAck,
  input  logic [DATA_W-1:0]  drmRdData,
  output logic               errFlag,
  output logic               donePulse,
  output logic [PAR_W-1:0]   parityOut
);

  localparam int DRUM_WORDS = NUM_TRACKS * (1 << (WORD_BITS + SECT_BITS));

  xfer_strobe_t stb;
  logic         dirWrite;
  logic         nextWcZero;
  logic         nextSectorStart;

  drum_xfer_ctrl #(
    .WORD_TIME   (WORD_TIME),
    .GAP_WORDS   (GAP_WORDS),
    .PAR_CLOBBER (PAR_CLOBBER)
  ) u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .startValid      (startValid),
    .drmPresent      (drmPresent),
    .clrErr          (clrErr),
    .memAck          (memAck),
    .drmAck          (drmAck),
    .dirWrite        (dirWrite),
    .nextWcZero      (nextWcZero),
    .nextSectorStart (nextSectorStart),
    .stb             (stb),
    .memReq          (memReq),
    .memWe           (memWe),
    .drmReq          (drmReq),
    .drmWe           (drmWe),
    .startReady      (startReady),
    .donePulse       (donePulse),
    .errFlag         (errFlag)
  );

  drum_xfer_dp #(
    .CORE_AW    (CORE_AW),
    .DA_W       (DA_W),
    .WC_W       (WC_W),
    .DATA_W     (DATA_W),
    .WORD_BITS  (WORD_BITS),
    .DRUM_WORDS (DRUM_WORDS)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .stb             (stb),
    .startWrite      (startWrite),
    .startCore       (startCore),
    .startDrum       (startDrum),
    .startCount      (startCount),
    .memRdData       (memRdData),
    .drmRdData       (drmRdData),
    .coreAddr        (memAddr),
    .drumAddr        (drmAddr),
    .memWrData       (memWrData),
    .drmWrData       (drmWrData),
    .parity          (parityOut),
    .dirWrite        (dirWrite),
    .nextWcZero      (nextWcZero),
    .nextSectorStart (nextSectorStart)
  );

endmodule

// File: tb/tb_drum_xfer_engine.sv
module tb_drum_xfer_engine;

  localparam int CORE_N = 64;
  localparam int DRUM_N = 48;   // 3 tracks x 2 sectors x 8 words
  localparam int SECT_N = 8;
  localparam int SHORT_D = 2;   // WORD_TIME
  localparam int LONG_D = 8;    // GAP_WORDS * WORD_TIME

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        startWrite = 1'b0;
  logic [5:0]  startCore = '0;
  logic [5:0]  startDrum = '0;
  logic [13:0] startCount = '0;
  logic        startReady;
  logic        clrErr = 1'b0;
  logic        drmPresent = 1'b1;
  logic        memReq, memWe, memAck;
  logic [5:0]  memAddr;
  logic [23:0] memWrData, memRdData;
  logic        drmReq, drmWe, drmAck;
  logic [5:0]  drmAddr;
  logic [23:0] drmWrData, drmRdData;
  logic        errFlag, donePulse;
  logic [11:0] parityOut;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int ackLat = 1;
  int seed = 0;
  int memCnt = 0;
  int drmCnt = 0;
  logic [23:0] coreMem [0:CORE_N-1];
  logic [23:0] drumMem [0:DRUM_N-1];

  drum_xfer_engine #(
    .WORD_BITS(3), .SECT_BITS(1), .TRACK_BITS(2), .NUM_TRACKS(3),
    .GAP_WORDS(4), .WORD_TIME(2), .CORE_AW(6), .WC_W(14), .DATA_W(24),
    .PAR_CLOBBER(1'b1)
  ) dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startWrite(startWrite),
    .startCore(startCore), .startDrum(startDrum), .startCount(startCount),
    .startReady(startReady), .clrErr(clrErr), .drmPresent(drmPresent),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .memAck(memAck), .memRdData(memRdData),
    .drmReq(drmReq), .drmWe(drmWe), .drmAddr(drmAddr), .drmWrData(drmWrData),
    .drmAck(drmAck), .drmRdData(drmRdData),
    .errFlag(errFlag), .donePulse(donePulse), .parityOut(parityOut)
  );

  always #5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pat(input int i, input int s);
    return 24'((i * 78901 + s * 40503 + 17) ^ 32'h005a5a5a);
  endfunction

  function automatic logic [11:0] parStep(input logic [11:0] p, input logic [23:0] w);
    logic [11:0] m;
    m = p ^ w[23:12];
    return {m[10:0], m[11]} ^ w[11:0];
  endfunction

  // Memory and drum responders: acknowledge after ackLat cycles, drop for a cycle after each ack
  initial begin
    memAck = 1'b0; drmAck = 1'b0; memRdData = '0; drmRdData = '0;
    forever begin
      @(negedge clk);
      if (memReq && !memAck) begin
        memCnt++;
        if (memCnt >= ackLat) begin
          memAck = 1'b1; memCnt = 0;
          if (memWe) coreMem[memAddr] = memWrData;
          else       memRdData = coreMem[memAddr];
        end
      end else begin
        memAck = 1'b0; memCnt = 0;
      end
      if (drmReq && !drmAck) begin
        drmCnt++;
        if (drmCnt >= ackLat) begin
          drmAck = 1'b1; drmCnt = 0;
          if (int'(drmAddr) < DRUM_N) begin
            if (drmWe) drumMem[drmAddr] = drmWrData;
            else       drmRdData = drumMem[drmAddr];
          end
        end
      end else begin
        drmAck = 1'b0; drmCnt = 0;
      end
    end
  end

  // One block with data, check value, done and (optionally) duration checks
  task automatic do_xfer(input bit wr, input int ca0, input int da0, input int n,
                         input int lat, input bit timed, input bit intrude, input string tg);
    logic [23:0] expCore [0:CORE_N-1];
    logic [23:0] expDrum [0:DRUM_N-1];
    logic [11:0] ep;
    int expDone, s, doneAt, mism, nd, endDa;
    bit clob;
    seed++;
    for (int i = 0; i < CORE_N; i++) begin coreMem[i] = pat(i, seed); expCore[i] = coreMem[i]; end
    for (int i = 0; i < DRUM_N; i++) begin drumMem[i] = pat(i + 500, seed); expDrum[i] = drumMem[i]; end
    ep = '0;
    expDone = 1 + 2 * n;
    for (int i = 0; i < n; i++) begin
      int ci;
      int di;
      ci = (ca0 + i) % CORE_N;
      di = (da0 + i) % DRUM_N;
      if (wr) begin ep = parStep(ep, coreMem[ci]); expDrum[di] = coreMem[ci]; end
      else    begin ep = parStep(ep, drumMem[di]); expCore[ci] = drumMem[di]; end
      if (i < n - 1) begin
        nd = (da0 + i + 1) % DRUM_N;
        expDone += ((nd % SECT_N) == 0) ? LONG_D : SHORT_D;
      end
    end
    endDa = (da0 + n) % DRUM_N;
    clob = wr && ((endDa % SECT_N) != 0);
    if (clob) begin expDrum[endDa] = {ep, 12'h000}; expDone += 2; end
    ackLat = lat;
    @(negedge clk);
    s = cyc;
    startValid = 1'b1; startWrite = wr; startCore = 6'(ca0);
    startDrum = 6'(da0); startCount = 14'(n);
    @(negedge clk);
    startValid = 1'b0;
    doneAt = -1;
    for (int k = 0; k < 800 && doneAt < 0; k++) begin
      if (donePulse) doneAt = cyc;
      else begin
        if (intrude && (k == 2 || k == 5)) begin
          startValid = 1'b1; startWrite = !wr; startCore = 6'd7;
          startDrum = 6'd20; startCount = 14'd1;
        end else startValid = 1'b0;
        @(negedge clk);
      end
    end
    startValid = 1'b0;
    chk(doneAt >= 0, {"R8 done seen ", tg}, doneAt, 1);
    if (timed) chk((doneAt - s) == expDone, {"duration ", tg}, doneAt - s, expDone);
    @(negedge clk);
    chk(!donePulse && startReady, {"R8 one-cycle done ", tg}, {donePulse, startReady}, 1);
    mism = 0;
    for (int i = 0; i < CORE_N; i++) if (coreMem[i] !== expCore[i]) mism++;
    for (int i = 0; i < DRUM_N; i++) if (drumMem[i] !== expDrum[i]) mism++;
    chk(mism == 0, {wr ? "R2 R4 data " : "R3 R4 data ", tg}, mism, 0);
    chk(parityOut == ep, {"R5 check value ", tg}, parityOut, ep);
  endtask

  initial begin
    wait (cyc >= 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s;
    int seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(startReady && !memReq && !drmReq && !errFlag && !donePulse && parityOut == 0,
        "R13 reset state", {startReady, memReq, drmReq, errFlag, donePulse}, 5'b10000);

    // Directed blocks
    do_xfer(1'b1, 3, 1, 5, 1, 1'b1, 1'b0, "R6 R11 mid-sector write");
    do_xfer(1'b0, 61, 5, 6, 1, 1'b1, 1'b0, "R7 R4 core wrap read");
    do_xfer(1'b1, 10, 12, 4, 3, 1'b0, 1'b0, "R11 R12 sector end slow ack");
    do_xfer(1'b1, 20, 46, 4, 1, 1'b1, 1'b0, "R1 drum wrap");
    do_xfer(1'b0, 30, 40, 9, 1, 1'b1, 1'b1, "R12 start ignored while busy");

    // Sweep over directions, lengths and every start position
    for (int wr = 0; wr < 2; wr++)
      for (int n = 1; n <= 9; n++)
        for (int da = 0; da < DRUM_N; da++)
          do_xfer(wr[0], (da * 5 + n) % CORE_N, da, n, 1, 1'b1, 1'b0, "R6/R7 sweep");

    // R9: absent store at start
    drmPresent = 1'b0;
    @(negedge clk);
    startValid = 1'b1; startWrite = 1'b1; startCore = 6'd0; startDrum = 6'd0; startCount = 14'd2;
    @(negedge clk);
    startValid = 1'b0;
    chk(errFlag && startReady && !memReq && !drmReq && !donePulse, "R9 absent at start",
        {errFlag, startReady, memReq, drmReq, donePulse}, 5'b11000);
    drmPresent = 1'b1;

    // R10: flag survives a good block, then clears
    do_xfer(1'b0, 4, 9, 2, 1, 1'b1, 1'b0, "R10 block with flag set");
    chk(errFlag, "R10 flag kept", errFlag, 1);
    clrErr = 1'b1;
    @(negedge clk);
    clrErr = 1'b0;
    chk(!errFlag, "R10 flag cleared", errFlag, 0);

    // R9: store disappears during the wait before the second word
    seed++;
    for (int i = 0; i < CORE_N; i++) coreMem[i] = pat(i, seed);
    for (int i = 0; i < DRUM_N; i++) drumMem[i] = pat(i + 500, seed);
    ackLat = 1;
    @(negedge clk);
    s = cyc;
    startValid = 1'b1; startWrite = 1'b1; startCore = 6'd8; startDrum = 6'd1; startCount = 14'd3;
    @(negedge clk);
    startValid = 1'b0;
    @(negedge clk);
    drmPresent = 1'b0;
    seen = 0;
    repeat (8) begin
      @(negedge clk);
      if (donePulse) seen++;
    end
    chk(seen == 0 && errFlag && startReady, "R9 abort mid-block", {seen[3:0], errFlag, startReady}, 6'b000011);
    chk(drumMem[1] == coreMem[8] && drumMem[2] == pat(502, seed), "R9 only first word moved",
        drumMem[2], pat(502, seed));
    drmPresent = 1'b1;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule